// File: doc/BRIEF.md
# Eight-Period Pulse Frequency Meter

The block measures the period of a slow external pulse train by counting reference ticks across eight consecutive input periods. One system clock drives every register. A free-running prescaler issues a one-cycle tick enable once every `TICK_DIV` system clocks, which gives a 1 MHz tick rate from a 10 MHz clock. The asynchronous input passes through a synchronizer chain. A rising edge is recognised when the current synchronized sample is high and the registered previous sample is low. No register is clocked by a derived or gated signal.

The first rising edge after reset opens a measurement window. The eighth rising edge after that closes the window, latches the tick total into the output register and pulses `valid_o` for one cycle. The closing edge also opens the next window, so results follow each other without gaps. The tick counter saturates at its maximum value and sets a sticky overflow flag, which is reported together with the result. With the default parameters, a 333 Hz input gives about 24000 counts per result.

Top module: `freq_meter`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `count_o`, `valid_o` and `ovf_o` are all 0.
- R2: After reset, the first rising edge of `pulse_i` only opens a window. No result is produced until eight further rising edges have arrived.
- R3: A result equals the number of tick enables, one every `TICK_DIV` system clocks, from the clock that acts on the opening edge up to the clock before the one that acts on the closing edge. For a window lasting a whole multiple of `TICK_DIV` clocks, this is the window length divided by `TICK_DIV`, whatever the duty cycle or the spread of the periods inside the window.
- R4: The edge that closes a window opens the next one. Consecutive `valid_o` pulses are therefore exactly eight input periods apart.
- R5: `valid_o` is high for exactly one system clock per result.
- R6: `valid_o` and the new `count_o` appear after the third rising system-clock edge following a rise of `pulse_i` (two synchronizer stages plus the edge register).
- R7: If a window holds more ticks than `2**CNT_W-1`, the result reads `2**CNT_W-1` and `ovf_o` is 1.
- R8: The overflow flag clears when a window opens. A result that follows an overflowed one without saturating itself reports `ovf_o` = 0.
- R9: `count_o` and `ovf_o` change only in the cycle where `valid_o` rises, and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pulse_i | input | 1 | Asynchronous pulse input to be measured |
| count_o | output | CNT_W | Tick total of the last completed window |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| ovf_o | output | 1 | Set when the last result saturated |

## Verification
The hardest case to reach is overflow followed by recovery. With a 16-bit counter, a saturating window would take more than 650,000 clocks. The bench therefore adds a second instance with an 8-bit counter and drives it with slow pulses until the result saturates. It then shortens the period so that the window that follows fits, and checks that the flag clears. Continuity between windows is checked with irregular gap lists, where the interval just after each closing edge has to be counted in the next result.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_e;
endpackage

// File: rtl/meter_tick_gen.sv
module meter_tick_gen #(
  parameter int TICK_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (div_q == LAST);
      div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/meter_edge_sync.sv
module meter_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], d_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // current high, previous low
  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/meter_window.sv
module meter_window
  import freq_meter_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int EDGES_PER_WIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o,
  output logic             ovf_o
);
  localparam int EW = (EDGES_PER_WIN > 1) ? $clog2(EDGES_PER_WIN) : 1;
  localparam logic [EW-1:0]    LAST_EDGE = EW'(EDGES_PER_WIN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  win_state_e       state_q;
  logic [EW-1:0]    edge_q;
  logic [CNT_W-1:0] ticks_q;
  logic             ovf_q;
  logic             close;

  assign close = rise_i && (state_q == WIN_RUN) && (edge_q == LAST_EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      edge_q  <= '0;
      ticks_q <= '0;
      ovf_q   <= 1'b0;
    end else if (rise_i) begin
      // opening or closing edge both start a fresh window
      state_q <= WIN_RUN;
      if (state_q == WIN_IDLE || close) begin
        edge_q  <= '0;
        ticks_q <= tick_i ? CNT_W'(1) : '0;
        ovf_q   <= 1'b0;
      end else begin
        edge_q <= edge_q + 1'b1;
        if (tick_i) begin
          if (ticks_q == CNT_MAX) ovf_q <= 1'b1;
          else                    ticks_q <= ticks_q + 1'b1;
        end
      end
    end else if (tick_i && state_q == WIN_RUN) begin
      if (ticks_q == CNT_MAX) ovf_q <= 1'b1;
      else                    ticks_q <= ticks_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= close;
      if (close) begin
        count_o <= ticks_q;
        ovf_o   <= ovf_q;
      end
    end
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W         = 16,
  parameter int TICK_DIV      = 10,
  parameter int EDGES_PER_WIN = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o,
  output logic             ovf_o
);
  logic rise;
  logic tick;

  meter_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  meter_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pulse_i),
    .rise_o(rise)
  );

  meter_window #(.CNT_W(CNT_W), .EDGES_PER_WIN(EDGES_PER_WIN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .tick_i (tick),
    .count_o(count_o),
    .valid_o(valid_o),
    .ovf_o  (ovf_o)
  );
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rise_i,
  input logic             tick_i,
  input logic             valid_i,
  input logic [CNT_W-1:0] count_i,
  input logic             ovf_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_valid_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ($stable(count_i) && $stable(ovf_i)));

  assert_ovf_saturated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |-> (count_i == CNT_MAX));

  assert_valid_after_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(rise_i));

  assert_tick_spaced_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> !tick_i);
endmodule

bind freq_meter freq_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rise_i (rise),
  .tick_i (tick),
  .valid_i(valid_o),
  .count_i(count_o),
  .ovf_i  (ovf_o)
);

// File: tb/tb_freq_meter.sv
module tb_freq_meter;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pulse_a = 1'b0;
  logic pulse_b = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cnt_a;
  logic        valid_a, ovf_a;
  logic [7:0]  cnt_b;
  logic        valid_b, ovf_b;

  freq_meter dut (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse_a),
    .count_o(cnt_a), .valid_o(valid_a), .ovf_o(ovf_a)
  );

  freq_meter #(.CNT_W(8)) dut_ovf (
    .clk_i(clk), .rst_ni(rst_ni), .pulse_i(pulse_b),
    .count_o(cnt_b), .valid_o(valid_b), .ovf_o(ovf_b)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  // result capture
  int na = 0, nb = 0;
  int a_cnt[16], a_ovf[16], a_cyc[16];
  int b_cnt[16], b_ovf[16];
  bit prev_va = 1'b0, prev_vb = 1'b0;
  int last_rise_a = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (valid_a && na < 16) begin
      a_cnt[na] = int'(cnt_a); a_ovf[na] = int'(ovf_a); a_cyc[na] = cyc; na++;
    end
    if (valid_b && nb < 16) begin
      b_cnt[nb] = int'(cnt_b); b_ovf[nb] = int'(ovf_b); nb++;
    end
    if (prev_va && valid_a) check(1'b0, "R5 valid_o width", 2, 1);
    if (prev_vb && valid_b) check(1'b0, "R5 ovf-instance valid width", 2, 1);
    prev_va = valid_a;
    prev_vb = valid_b;
  end

  task automatic send_a(input int gap, input int high);
    pulse_a = 1'b1;
    last_rise_a = cyc;
    repeat (high) @(negedge clk);
    pulse_a = 1'b0;
    repeat (gap - high) @(negedge clk);
  endtask

  task automatic send_b(input int gap, input int high);
    pulse_b = 1'b1;
    repeat (high) @(negedge clk);
    pulse_b = 1'b0;
    repeat (gap - high) @(negedge clk);
  endtask

  task automatic t_reset;
    check(cnt_a == 0 && valid_a == 0 && ovf_a == 0, "R1 outputs in reset", int'(cnt_a), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(cnt_a == 0, "R1 count_o after release", int'(cnt_a), 0);
    check(valid_a == 0, "R1 valid_o after release", int'(valid_a), 0);
    check(ovf_a == 0, "R1 ovf_o after release", int'(ovf_a), 0);
    check(cnt_b == 0 && ovf_b == 0, "R1 ovf instance after release", int'(cnt_b), 0);
  endtask

  task automatic t_first_window;
    for (int i = 0; i < 8; i++) send_a(1000, 300);
    check(na == 0, "R2 no result before ninth edge", na, 0);
    send_a(1000, 300);
    check(na == 1, "R2 result on ninth edge", na, 1);
    check(a_cnt[0] == 800, "R3 count period 1000", a_cnt[0], 800);
    check(a_cyc[0] - last_rise_a == 3, "R6 latency", a_cyc[0] - last_rise_a, 3);
    check(a_ovf[0] == 0, "R8 no overflow", a_ovf[0], 0);
  endtask

  task automatic t_back_to_back;
    // near-full duty: high 995, low 5
    for (int i = 0; i < 8; i++) send_a(1000, 995);
    check(na == 2, "R4 second result", na, 2);
    check(a_cnt[1] == 800, "R3 count high duty", a_cnt[1], 800);
    check(a_cyc[1] - a_cyc[0] == 8000, "R4 result spacing", a_cyc[1] - a_cyc[0], 8000);
  endtask

  task automatic t_mixed;
    int g[8] = '{500, 1500, 2000, 700, 300, 1200, 1800, 600};
    // window = 1000 (after last closing edge) + first seven gaps
    for (int i = 0; i < 8; i++) send_a(g[i], 100);
    check(na == 3, "R4 third result", na, 3);
    check(a_cnt[2] == 900, "R3 count irregular gaps", a_cnt[2], 900);
  endtask

  task automatic t_hold;
    int bad = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cnt_a != 16'd900 || valid_a || ovf_a) bad++;
    end
    check(bad == 0, "R9 result held while window open", bad, 0);
  endtask

  task automatic t_reset_mid;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(cnt_a == 0 && ovf_a == 0 && valid_a == 0, "R1 reset mid-window", int'(cnt_a), 0);
    rst_ni = 1'b1;
    repeat (7) @(negedge clk);
    for (int i = 0; i < 8; i++) send_a(2500, 1250);
    check(na == 3, "R2 no result before ninth edge after reset", na, 3);
    send_a(2500, 1250);
    check(na == 4, "R2 result after reset", na, 4);
    check(a_cnt[3] == 2000, "R3 count period 2500", a_cnt[3], 2000);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 9; i++) send_b(400, 200);
    check(nb == 1, "R7 saturating result present", nb, 1);
    check(b_cnt[0] == 255, "R7 saturated count", b_cnt[0], 255);
    check(b_ovf[0] == 1, "R7 overflow flag", b_ovf[0], 1);
    // window = 400 + 7*200 = 1800 clocks
    for (int i = 0; i < 8; i++) send_b(200, 50);
    check(nb == 2, "R8 following result present", nb, 2);
    check(b_cnt[1] == 180, "R8 count after overflow", b_cnt[1], 180);
    check(b_ovf[1] == 0, "R8 flag cleared", b_ovf[1], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_window();
    t_back_to_back();
    t_mixed();
    t_hold();
    t_reset_mid();
    t_overflow();
    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule